// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Prescaler

This block is a 16-bit up-counter made of two byte halves. It has two clock sources. In timer mode it counts an internal instruction tick, which fires once every four system clocks. In counter mode it counts rising edges on an external clock pin. A selectable divider of 1, 2, 4 or 8 sits in front of the counter. In counter mode the divided pulse can go through one extra alignment stage to the system clock (synchronous mode) or skip that stage (asynchronous mode). A run bit gates all counting. A wrap from 0xFFFF to 0x0000 raises a sticky overflow flag.

Software reaches the block through a byte-wide write port and a read port, both addressed. Address 0 is the low byte, address 1 the high byte, address 2 the control byte and address 3 reads zero. In the control byte, bit 0 is run, bit 1 selects the external source, bit 2 selects asynchronous counting, bits 5:4 hold the divider code and bit 7 is the overflow flag. The external pin is brought into the system clock domain by two flops with edge detection. Everything runs on the single system clock.

Top module: `tmr16_ctr`

## Requirements
- R1: After reset the counter is 0x0000, the control byte reads 0x00 and `ovf_flag` is low.
- R2: With run=1 and the source bit clear, the divider receives one event every fourth system clock, and the counter advances by at most one per clock.
- R3: Divider code 0, 1, 2 and 3 in control bits 5:4 passes every 1st, 2nd, 4th and 8th event, respectively, to the counter.
- R4: With the source bit set, each rising edge of `ext_clk` seen through a two-flop synchronizer is one divider event.
- R5: After counting is enabled in counter mode, a rising edge counts only once the synchronized input has been seen low. An input that idles high therefore counts nothing until it has fallen.
- R6: In counter mode with control bit 2 clear, the divider output passes through one extra register before it reaches the counter. With bit 2 set, it increments the counter in the same clock.
- R7: In synchronous counter mode, `halt` high keeps the counter from advancing while the divider goes on counting edges.
- R8: With run=0 the counter and the divider hold their values.
- R9: A wrap from 0xFFFF to 0x0000 sets the flag (control bit 7 and `ovf_flag`). The flag stays set until a control write with bit 7 at 0. A control write with bit 7 at 1 leaves the flag unchanged.
- R10: A write to address 0 or 1 loads that byte of the counter, clears the divider and wins over an increment in the same clock.
- R11: A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | External count input, asynchronous |
| halt | input | 1 | Shuts off the alignment stage in synchronous counter mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low, 1 high, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `ext_clk` holds each level for at least two system clocks, so that every real edge reaches the edge detector once. They also assume that `halt` matters only in synchronous counter mode. The stimulus holds each external level for several clocks. It raises `halt` only while the block is in synchronous counter mode. It changes every input half a clock away from the sampling edge. A behavioural model in the bench predicts the selected read byte and the flag on every clock. The model is checked at the opposite clock edge.

// File: rtl/tmr16_ctr.sv
module tmr16_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic       halt,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       ovf_flag
);
  localparam int CW = 16;
  localparam int BW = CW / 2;
  localparam int PW = 3;

  logic [CW-1:0] cnt;
  logic [PW-1:0] pre;
  logic [1:0]    q;
  logic          s1, s2, s3, armed, pq;
  logic          run, src, nosync, flag;
  logic [1:0]    ps;

  wire          wr_lo  = wr_en && wr_addr == 2'd0;
  wire          wr_hi  = wr_en && wr_addr == 2'd1;
  wire          wr_ct  = wr_en && wr_addr == 2'd2;
  wire          wr_byt = wr_lo | wr_hi;
  wire          rise   = s2 & ~s3;
  wire          tick   = &q;
  wire          ev     = run & (src ? (rise & armed) : tick);
  wire [PW-1:0] pre_n  = pre + 3'd1;
  wire [PW-1:0] mask   = ~(3'b111 << ps);
  wire          pulse  = ev & ((pre_n & mask) == 3'd0);
  wire          sync_m = src & ~nosync;
  wire          inc    = run & (sync_m ? pq : pulse) & ~wr_byt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; pre <= '0; q <= '0;
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      armed <= 1'b0; pq <= 1'b0;
      run <= 1'b0; src <= 1'b0; nosync <= 1'b0; ps <= '0; flag <= 1'b0;
    end else begin
      s1 <= ext_clk;
      s2 <= s1;
      s3 <= s2;
      q  <= q + 2'd1;
      armed <= run & src & (armed | ~s2);
      if (wr_byt) begin
        pre <= '0;
        pq  <= 1'b0;
      end else begin
        if (ev) pre <= pre_n;
        pq <= pulse & ~halt;
      end
      if (wr_lo)      cnt[BW-1:0]  <= wr_data;
      else if (wr_hi) cnt[CW-1:BW] <= wr_data;
      else if (inc)   cnt <= cnt + 1'b1;
      if (wr_ct) begin
        run    <= wr_data[0];
        src    <= wr_data[1];
        nosync <= wr_data[2];
        ps     <= wr_data[5:4];
      end
      if (inc && (&cnt))              flag <= 1'b1;
      else if (wr_ct && !wr_data[7])  flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cnt[BW-1:0];
      2'd1:    rd_data = cnt[CW-1:BW];
      2'd2:    rd_data = {flag, 1'b0, ps, 1'b0, nosync, src, run};
      default: rd_data = 8'h00;
    endcase
  end

  assign ovf_flag = flag;
endmodule

// File: rtl/tmr16_ctr_chk.sv
module tmr16_ctr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        halt,
  input logic [15:0] cnt,
  input logic        ovf_flag,
  input logic        run,
  input logic        src,
  input logic        nosync,
  input logic        pq
);
  wire byte_wr = wr_en && wr_addr <= 2'd1;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !byte_wr) |=> $stable(cnt));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && run && src && !nosync && !pq && !byte_wr) |=> $stable(cnt));

  // R9
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == 16'hFFFF && cnt == 16'h0000));

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_en && wr_addr == 2'd2 && !wr_data[7])) |=> ovf_flag);
endmodule

bind tmr16_ctr tmr16_ctr_chk chk_i (.*);

// File: tb/tmr16_ctr_tb.sv
module tmr16_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       halt = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       ovf_flag;

  int nchk = 0;
  int nfail = 0;
  string phase = "R1";

  tmr16_ctr dut_i (.*);

  always #4 clk = ~clk;

  int m_cnt, m_pre, m_q, m_s1, m_s2, m_s3, m_armed, m_pq;
  int m_run, m_src, m_nosync, m_ps, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_q = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_armed = 0; m_pq = 0; m_run = 0; m_src = 0; m_nosync = 0; m_ps = 0; m_flag = 0;
    end else begin
      int div, npre, ev, pulse, inc, bw;
      div  = 1 << m_ps;
      ev   = m_run && (m_src ? (m_s2 && !m_s3 && m_armed) : (m_q == 3));
      npre = (m_pre + 1) % 8;
      pulse = ev && (npre % div == 0);
      bw   = wr_en && wr_addr < 2;
      inc  = m_run && !bw && ((m_src && !m_nosync) ? m_pq : pulse);
      m_armed = m_run && m_src && (m_armed || !m_s2);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
      m_q = (m_q + 1) % 4;
      if (bw) begin m_pre = 0; m_pq = 0; end
      else begin
        if (ev) m_pre = npre;
        m_pq = pulse && !halt;
      end
      if (inc && m_cnt == 65535) m_flag = 1;
      else if (wr_en && wr_addr == 2 && !wr_data[7]) m_flag = 0;
      if (wr_en && wr_addr == 0) m_cnt = (m_cnt & 'hFF00) | wr_data;
      else if (wr_en && wr_addr == 1) m_cnt = (m_cnt & 'h00FF) | (int'(wr_data) << 8);
      else if (inc) m_cnt = (m_cnt + 1) % 65536;
      if (wr_en && wr_addr == 2) begin
        m_run = wr_data[0]; m_src = wr_data[1]; m_nosync = wr_data[2]; m_ps = wr_data[5:4];
      end
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_cnt % 256;
      1: return m_cnt / 256;
      2: return (m_flag << 7) | (m_ps << 4) | (m_nosync << 2) | (m_src << 1) | m_run;
      default: return 0;
    endcase
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nchk++;
      if (int'(rd_data) != exp_rd(rd_addr) || int'(ovf_flag) != m_flag) begin
        nfail++;
        $display("FAIL %s addr=%0d rd=%h exp=%h flag=%0d exp_flag=%0d",
                 phase, rd_addr, rd_data, exp_rd(rd_addr), ovf_flag, m_flag);
      end
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(int a, int e, string tag);
    rd_addr = 2'(a);
    #1;
    nchk++;
    if (int'(rd_data) != e) begin
      nfail++;
      $display("FAIL %s addr=%0d rd=%h exp=%h", tag, a, rd_data, e);
    end
  endtask

  task automatic toggle(int n, int half);
    for (int i = 0; i < n; i++) begin
      ext_clk = ~ext_clk;
      if (i % 3 == 0) rd_addr = 2'd1; else rd_addr = 2'd0;
      step(half);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    expect_rd(0, 0, "R1");
    expect_rd(1, 0, "R1");
    expect_rd(2, 0, "R1");
    expect_rd(3, 0, "R11");
    rd_addr = 2'd0;

    for (int p = 0; p < 4; p++) begin
      phase = (p == 0) ? "R2" : "R3";
      wr(0, 0);
      wr(1, 0);
      wr(2, 1 | (p << 4));
      step(40 * (1 << p));
      rd_addr = 2'd1; step(2); rd_addr = 2'd0;
    end

    phase = "R8";
    wr(2, 'h30);
    step(60);

    phase = "R10";
    wr(0, 'h5A);
    expect_rd(0, 'h5A, "R10");
    wr(1, 'hA5);
    expect_rd(1, 'hA5, "R10");
    rd_addr = 2'd0;

    phase = "R5";
    ext_clk = 1'b1;
    wr(2, 'h06);
    step(6);
    wr(0, 0); wr(1, 0);
    wr(2, 'h07);
    step(6);
    toggle(20, 5);
    phase = "R5";
    wr(2, 'h06);
    ext_clk = 1'b0;
    step(6);
    wr(0, 0);
    wr(2, 'h03);
    step(6);
    toggle(20, 4);

    phase = "R4";
    for (int p = 1; p < 4; p++) begin
      wr(2, 'h03 | (p << 4));
      toggle(34, 3);
    end

    phase = "R6";
    wr(2, 'h07);
    toggle(24, 3);
    wr(2, 'h03);
    toggle(24, 3);

    phase = "R7";
    wr(2, 'h13);
    halt = 1'b1;
    toggle(30, 3);
    halt = 1'b0;
    toggle(20, 3);

    phase = "R9";
    wr(2, 'h00);
    wr(1, 'hFF);
    wr(0, 'hF0);
    wr(2, 'h01);
    step(90);
    expect_rd(2, 'h81, "R9");
    rd_addr = 2'd2;
    wr(2, 'h80);
    step(10);
    expect_rd(2, 'h80, "R9");
    wr(2, 'h00);
    step(3);
    expect_rd(2, 'h00, "R9");
    expect_rd(3, 0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule